// File: doc/BRIEF.md
# Decimal-Word Accumulator Processor

This block is a small multi-cycle processor built around a single accumulator. It runs a program held in a private memory of 100 words, where each word is a signed decimal value in the range -9999 to +9999. Code and data share that one memory. To execute an instruction, the machine reads a word and divides it by one hundred. The quotient is the operation code and the remainder is an operand address. The machine then performs the operation.

A host fills the memory through a word-write port while the machine is idle, then pulses `start`. The program exchanges words with the outside world through two valid/ready handshakes, one for input and one for output. The machine stalls as long as a handshake is pending. When the program stops, `halted` rises. The `errFlag` output marks an abnormal stop. The `ovfFlag` output records that an arithmetic result left the four-digit range at some point.

Top module: `decimal_acc_cpu`

## Requirements
- R1: Memory-port writes (`loadEn`, `loadAddr`, `loadData`) store a word at any address while the machine is idle. Idle means after reset or while halted. While a program runs, such writes are ignored and the stored word is unchanged.
- R2: A `start` pulse while idle sets the instruction pointer to 0 and clears the accumulator, the instruction register, `errFlag` and `ovfFlag`. Execution then begins at address 0.
- R3: A non-negative word W is decoded as operation code W/100 and address W%100. Data words may be negative.
- R4: Code 10 raises `inReady` and waits for `inValid`. On the handshake it writes `inData` to the addressed word.
- R5: Code 11 raises `outValid` with the addressed word on `outData`. It holds both, unchanged, until `outReady`.
- R6: Code 20 copies the addressed word into the accumulator. Code 21 copies the accumulator into the addressed word.
- R7: Codes 30, 31 and 33 add, subtract and multiply the addressed word into the accumulator. A result with magnitude above 9999 keeps its sign, takes its magnitude modulo 10000, and sets the sticky `ovfFlag`.
- R8: Code 32 divides the accumulator by the addressed word and truncates toward zero. A zero divisor halts the machine with `errFlag` high before any later instruction runs.
- R9: Code 40 jumps to the address. Code 41 jumps only if the accumulator is negative. Code 42 jumps only if the accumulator is zero. Otherwise the pointer steps by one.
- R10: Code 43 stops the machine. `halted` goes high with `errFlag` low and stays high until the next `start`.
- R11: An undefined code, or a negative instruction word, halts the machine with `errFlag` high. So does a fetch from an address past 99.
- R12: Every instruction takes three clock cycles (fetch, decode, execute), plus any handshake wait. A fetch past the end takes one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Memory-port write strobe |
| loadAddr | input | 7 | Memory-port word address |
| loadData | input | 16 | Memory-port word (signed) |
| start | input | 1 | Begin execution from address 0 |
| inData | input | 16 | Input word (signed) |
| inValid | input | 1 | Input word available |
| inReady | output | 1 | Machine waits for an input word |
| outData | output | 16 | Output word (signed) |
| outValid | output | 1 | Output word available |
| outReady | input | 1 | Receiver accepts the output word |
| halted | output | 1 | Machine stopped |
| errFlag | output | 1 | Stop was caused by a fault |
| ovfFlag | output | 1 | Sticky arithmetic range overflow |

## Verification
Two memory writes can land in the same cycle. One is the completion of an input handshake. The other is a memory-port write aimed at the same address. The bench provokes this by asserting `inValid` and a port write to the read target in one cycle, after the read instruction has stalled for several cycles. During that stall it also sends a port write to a second address. Both cases are judged by the words the program later writes out. The first must equal the input word, and the second must equal the word stored before `start`.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  localparam int WORD_W    = 16;
  localparam int OP_W      = 7;
  localparam int MEM_WORDS = 100;
  localparam int RADIX     = 100;
  localparam int WORD_MAX  = 9999;
  localparam int WRAP_MOD  = WORD_MAX + 1;
  localparam int WIDE_W    = 32;

  typedef logic signed [WORD_W-1:0] word_t;

  localparam logic [OP_W-1:0] OP_READ  = 7'd10;
  localparam logic [OP_W-1:0] OP_WRITE = 7'd11;
  localparam logic [OP_W-1:0] OP_LOAD  = 7'd20;
  localparam logic [OP_W-1:0] OP_STORE = 7'd21;
  localparam logic [OP_W-1:0] OP_ADD   = 7'd30;
  localparam logic [OP_W-1:0] OP_SUB   = 7'd31;
  localparam logic [OP_W-1:0] OP_DIV   = 7'd32;
  localparam logic [OP_W-1:0] OP_MUL   = 7'd33;
  localparam logic [OP_W-1:0] OP_JMP   = 7'd40;
  localparam logic [OP_W-1:0] OP_JNEG  = 7'd41;
  localparam logic [OP_W-1:0] OP_JZERO = 7'd42;
  localparam logic [OP_W-1:0] OP_STOP  = 7'd43;

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_DECODE, ST_EXEC, ST_HALT} state_t;
  typedef enum logic [1:0] {ACC_HOLD, ACC_LOAD, ACC_ALU} accSel_t;
  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV} aluOp_t;

  typedef struct packed {
    logic    clear;
    logic    irLoad;
    logic    decLoad;
    accSel_t accSel;
    aluOp_t  aluOp;
    logic    memWrAcc;
    logic    memWrIn;
    logic    ipInc;
    logic    ipJump;
  } ctlStrobe_t;
endpackage

// File: rtl/dacc_datapath.sv
module dacc_datapath
  import dacc_pkg::*;
#(
  parameter int DEPTH = MEM_WORDS,
  localparam int AW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      ctl,
  input  logic            loadWrEn,
  input  logic [AW-1:0]   loadAddr,
  input  word_t           loadData,
  input  word_t           inData,
  output logic [OP_W-1:0] opcode,
  output logic            accNeg,
  output logic            accZero,
  output logic            operandZero,
  output logic            ipPastEnd,
  output word_t           operand,
  output logic            ovfFlag
);
  word_t mem [DEPTH];
  word_t ir;
  word_t acc;
  word_t fetchWord;
  word_t wrapped;
  word_t wrData;
  logic [AW-1:0] ip;
  logic [AW-1:0] addrReg;
  logic [AW-1:0] addrNext;
  logic [AW-1:0] wrAddr;
  logic [OP_W-1:0] opNext;
  logic wrEn;
  logic ovfNow;
  logic signed [WIDE_W-1:0] aWide, bWide, wide, mag, wrapMag;

  // instruction split: quotient and remainder by the decimal radix
  always_comb begin
    if (ir[WORD_W-1]) begin
      opNext   = '0;
      addrNext = '0;
    end else begin
      opNext   = OP_W'(int'(ir) / RADIX);
      addrNext = AW'(int'(ir) % RADIX);
    end
  end

  always_comb begin
    fetchWord = (int'(ip) < DEPTH) ? mem[ip] : '0;
    operand   = (int'(addrReg) < DEPTH) ? mem[addrReg] : '0;
  end

  // arithmetic on a wide signed value, folded back into four digits
  always_comb begin
    aWide = {{(WIDE_W-WORD_W){acc[WORD_W-1]}}, acc};
    bWide = {{(WIDE_W-WORD_W){operand[WORD_W-1]}}, operand};
    unique case (ctl.aluOp)
      ALU_ADD: wide = aWide + bWide;
      ALU_SUB: wide = aWide - bWide;
      ALU_MUL: wide = aWide * bWide;
      default: wide = (bWide == 0) ? aWide : aWide / bWide;
    endcase
    mag     = wide[WIDE_W-1] ? -wide : wide;
    wrapMag = mag % WRAP_MOD;
    ovfNow  = mag > WORD_MAX;
    wrapped = wide[WIDE_W-1] ? -wrapMag[WORD_W-1:0] : wrapMag[WORD_W-1:0];
  end

  // single write port: execution has priority, the host port is gated upstream
  always_comb begin
    wrEn   = 1'b0;
    wrAddr = loadAddr;
    wrData = loadData;
    if (ctl.memWrIn) begin
      wrEn = 1'b1; wrAddr = addrReg; wrData = inData;
    end else if (ctl.memWrAcc) begin
      wrEn = 1'b1; wrAddr = addrReg; wrData = acc;
    end else if (loadWrEn) begin
      wrEn = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn && int'(wrAddr) < DEPTH) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ip      <= '0;
      ir      <= '0;
      acc     <= '0;
      addrReg <= '0;
      opcode  <= '0;
      ovfFlag <= 1'b0;
    end else if (ctl.clear) begin
      ip      <= '0;
      ir      <= '0;
      acc     <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (ctl.irLoad) ir <= fetchWord;
      if (ctl.decLoad) begin
        opcode  <= opNext;
        addrReg <= addrNext;
      end
      if (ctl.ipJump)     ip <= addrReg;
      else if (ctl.ipInc) ip <= ip + 1'b1;
      unique case (ctl.accSel)
        ACC_LOAD: acc <= operand;
        ACC_ALU: begin
          acc <= wrapped;
          if (ovfNow) ovfFlag <= 1'b1;
        end
        default: acc <= acc;
      endcase
    end
  end

  assign accNeg      = acc[WORD_W-1];
  assign accZero     = (acc == '0);
  assign operandZero = (operand == '0);
  assign ipPastEnd   = int'(ip) >= DEPTH;

  assert_acc_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    (acc >= -WORD_MAX) && (acc <= WORD_MAX));

  assert_fetch_in_range_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.irLoad |-> !ipPastEnd);
endmodule

// File: rtl/dacc_control.sv
module dacc_control
  import dacc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            loadEn,
  input  logic [OP_W-1:0] opcode,
  input  logic            accNeg,
  input  logic            accZero,
  input  logic            operandZero,
  input  logic            ipPastEnd,
  input  logic            inValid,
  input  logic            outReady,
  output ctlStrobe_t      ctl,
  output logic            loadWrEn,
  output logic            inReady,
  output logic            outValid,
  output logic            halted,
  output logic            errFlag
);
  state_t state, nextState;
  logic setErr;

  always_comb begin
    ctl       = '0;
    nextState = state;
    setErr    = 1'b0;
    loadWrEn  = 1'b0;
    inReady   = 1'b0;
    outValid  = 1'b0;
    unique case (state)
      ST_IDLE, ST_HALT: begin
        loadWrEn = loadEn;
        if (start) begin
          ctl.clear = 1'b1;
          nextState = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (ipPastEnd) begin
          setErr = 1'b1; nextState = ST_HALT;
        end else begin
          ctl.irLoad = 1'b1; nextState = ST_DECODE;
        end
      end
      ST_DECODE: begin
        ctl.decLoad = 1'b1;
        nextState   = ST_EXEC;
      end
      default: begin
        nextState = ST_FETCH;
        unique case (opcode)
          OP_READ: begin
            inReady = 1'b1;
            if (inValid) begin
              ctl.memWrIn = 1'b1; ctl.ipInc = 1'b1;
            end else nextState = ST_EXEC;
          end
          OP_WRITE: begin
            outValid = 1'b1;
            if (outReady) ctl.ipInc = 1'b1;
            else nextState = ST_EXEC;
          end
          OP_LOAD: begin
            ctl.accSel = ACC_LOAD; ctl.ipInc = 1'b1;
          end
          OP_STORE: begin
            ctl.memWrAcc = 1'b1; ctl.ipInc = 1'b1;
          end
          OP_ADD: begin
            ctl.accSel = ACC_ALU; ctl.aluOp = ALU_ADD; ctl.ipInc = 1'b1;
          end
          OP_SUB: begin
            ctl.accSel = ACC_ALU; ctl.aluOp = ALU_SUB; ctl.ipInc = 1'b1;
          end
          OP_MUL: begin
            ctl.accSel = ACC_ALU; ctl.aluOp = ALU_MUL; ctl.ipInc = 1'b1;
          end
          OP_DIV: begin
            ctl.aluOp = ALU_DIV;
            if (operandZero) begin
              setErr = 1'b1; nextState = ST_HALT;
            end else begin
              ctl.accSel = ACC_ALU; ctl.ipInc = 1'b1;
            end
          end
          OP_JMP:   ctl.ipJump = 1'b1;
          OP_JNEG:  begin ctl.ipJump = accNeg;  ctl.ipInc = !accNeg;  end
          OP_JZERO: begin ctl.ipJump = accZero; ctl.ipInc = !accZero; end
          OP_STOP:  nextState = ST_HALT;
          default: begin
            setErr = 1'b1; nextState = ST_HALT;
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.clear)   errFlag <= 1'b0;
      else if (setErr) errFlag <= 1'b1;
    end
  end

  assign halted = (state == ST_HALT);

  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    halted && !start |=> halted);

  assert_err_halted_R11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> halted);

  assert_in_wait_R4: assert property (@(posedge clk) disable iff (!rstN)
    inReady && !inValid |=> inReady);

  assert_io_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  assert_fetch_decode_R12: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH) && !ipPastEnd |=> (state == ST_DECODE));
endmodule

// File: rtl/decimal_acc_cpu.sv
module decimal_acc_cpu
  import dacc_pkg::*;
#(
  parameter int DEPTH = MEM_WORDS,
  localparam int AW = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadEn,
  input  logic [AW-1:0]            loadAddr,
  input  logic signed [WORD_W-1:0] loadData,
  input  logic                     start,
  input  logic signed [WORD_W-1:0] inData,
  input  logic                     inValid,
  output logic                     inReady,
  output logic signed [WORD_W-1:0] outData,
  output logic                     outValid,
  input  logic                     outReady,
  output logic                     halted,
  output logic                     errFlag,
  output logic                     ovfFlag
);
  ctlStrobe_t ctl;
  logic [OP_W-1:0] opcode;
  logic accNeg, accZero, operandZero, ipPastEnd, loadWrEn;

  dacc_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .loadEn(loadEn),
    .opcode(opcode), .accNeg(accNeg), .accZero(accZero),
    .operandZero(operandZero), .ipPastEnd(ipPastEnd),
    .inValid(inValid), .outReady(outReady), .ctl(ctl),
    .loadWrEn(loadWrEn), .inReady(inReady), .outValid(outValid),
    .halted(halted), .errFlag(errFlag)
  );

  dacc_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loadWrEn(loadWrEn),
    .loadAddr(loadAddr), .loadData(loadData), .inData(inData),
    .opcode(opcode), .accNeg(accNeg), .accZero(accZero),
    .operandZero(operandZero), .ipPastEnd(ipPastEnd),
    .operand(outData), .ovfFlag(ovfFlag)
  );

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));
endmodule

// File: tb/decimal_acc_cpu_tb.sv
module decimal_acc_cpu_tb;
  localparam int AW = 7;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic signed [15:0] loadData = '0;
  logic start = 1'b0;
  logic signed [15:0] inData = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic signed [15:0] outData;
  logic outValid;
  logic outReady = 1'b1;
  logic halted, errFlag, ovfFlag;

  int total = 0;
  int bad = 0;
  int cycleCount = 0;
  int inQ[8];
  int inCount = 0;
  int inIdx = 0;
  int outQ[8];
  int outCount = 0;
  int vals[13] = '{0, 1, -1, 7, -7, 99, 100, -250, 4999, 5000, -5001, 9999, -9999};
  int ops[4] = '{30, 31, 32, 33};

  always #5 clk = ~clk;

  decimal_acc_cpu u_dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .start(start), .inData(inData), .inValid(inValid),
    .inReady(inReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .halted(halted), .errFlag(errFlag), .ovfFlag(ovfFlag)
  );

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 190000) begin
      total++; bad++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", cycleCount, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic putWord(input int a, input int v);
    loadEn = 1'b1; loadAddr = AW'(a); loadData = 16'(v);
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic updateIn();
    inValid = (inIdx < inCount);
    inData  = (inIdx < inCount) ? 16'(inQ[inIdx]) : '0;
  endtask

  task automatic runProg(output int cyc);
    logic fire;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; inIdx = 0; outCount = 0;
    updateIn();
    while (!halted && cyc < 600) begin
      fire = inReady && inValid;
      if (outValid && outReady && outCount < 8) begin
        outQ[outCount] = int'(outData);
        outCount++;
      end
      @(negedge clk);
      cyc++;
      if (fire) inIdx++;
      updateIn();
    end
    inValid = 1'b0;
    if (cyc >= 600) check("R10 run did not stop", cyc, -1);
  endtask

  task automatic waitOut(output int v);
    v = -99999;
    for (int k = 0; k < 20; k++) begin
      if (outValid) begin
        v = int'(outData);
        @(negedge clk);
        return;
      end
      @(negedge clk);
    end
  endtask

  function automatic void model(input int op, input int a, input int b,
                                output int res, output int ovf);
    longint r, qa, qb, mag, m;
    qa = (a < 0) ? -a : a;
    qb = (b < 0) ? -b : b;
    case (op)
      30: r = longint'(a) + longint'(b);
      31: r = longint'(a) - longint'(b);
      33: r = longint'(a) * longint'(b);
      default: begin
        r = qa / qb;
        if ((a < 0) != (b < 0)) r = -r;
      end
    endcase
    mag = (r < 0) ? -r : r;
    ovf = (mag > 9999) ? 1 : 0;
    m   = mag % 10000;
    res = int'((r < 0) ? -m : m);
  endfunction

  initial begin
    int cyc, res, ovf, v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 R4 R5 reset state
    check("R10 reset halted", int'(halted), 0);
    check("R4 reset inReady", int'(inReady), 0);
    check("R5 reset outValid", int'(outValid), 0);
    check("R11 reset errFlag", int'(errFlag), 0);
    check("R7 reset ovfFlag", int'(ovfFlag), 0);

    // R3 R6 R7 R8 R12: arithmetic sweep with load/op/store/write/stop
    for (int o = 0; o < 4; o++) begin
      putWord(0, 2010); putWord(1, ops[o] * 100 + 11); putWord(2, 2112);
      putWord(3, 1112); putWord(4, 4300);
      for (int i = 0; i < 13; i++) begin
        for (int j = 0; j < 13; j++) begin
          putWord(10, vals[i]); putWord(11, vals[j]);
          inCount = 0;
          runProg(cyc);
          if (ops[o] == 32 && vals[j] == 0) begin
            check("R8 divide by zero errFlag", int'(errFlag), 1);
            check("R8 divide by zero no output", outCount, 0);
            check("R12 divide by zero cycles", cyc, 6);
          end else begin
            model(ops[o], vals[i], vals[j], res, ovf);
            check("R5 one output", outCount, 1);
            check(ops[o] == 32 ? "R8 R3 quotient" : "R7 R3 result", outQ[0], res);
            check("R7 overflow flag", int'(ovfFlag), ovf);
            check("R10 clean stop", int'(errFlag), 0);
            check("R12 five instructions", cyc, 15);
          end
        end
      end
    end

    // R2 R6: accumulator starts cleared; add to zero then store and write
    putWord(0, 3010); putWord(1, 2111); putWord(2, 1111); putWord(3, 4300);
    putWord(10, 42);
    runProg(cyc);
    check("R2 acc cleared at start", outQ[0], 42);
    check("R2 ovf cleared at start", int'(ovfFlag), 0);
    check("R6 store then write count", outCount, 1);

    // R7 sticky overflow: 9000+2000 wraps to 1000, then minus 2000
    putWord(0, 2010); putWord(1, 3011); putWord(2, 3111); putWord(3, 2112);
    putWord(4, 1112); putWord(5, 4300); putWord(10, 9000); putWord(11, 2000);
    runProg(cyc);
    check("R7 wrap then subtract", outQ[0], -1000);
    check("R7 sticky ovfFlag", int'(ovfFlag), 1);

    // R9 R4 negative branch: read A, read B, A-B, branch if negative
    putWord(0, 1030); putWord(1, 1031); putWord(2, 2030); putWord(3, 3131);
    putWord(4, 4107); putWord(5, 1130); putWord(6, 4300); putWord(7, 1131);
    putWord(8, 4300);
    inQ[0] = 3; inQ[1] = 5; inCount = 2; runProg(cyc);
    check("R9 negative taken", outQ[0], 5);
    check("R4 both inputs consumed", inIdx, 2);
    inQ[0] = 5; inQ[1] = 3; runProg(cyc);
    check("R9 negative not taken", outQ[0], 5);
    inQ[0] = -4; inQ[1] = -4; runProg(cyc);
    check("R9 zero difference not negative", outQ[0], -4);

    // R9 zero branch
    putWord(0, 1030); putWord(1, 2030); putWord(2, 4205); putWord(3, 1130);
    putWord(4, 4300); putWord(5, 1131); putWord(6, 4300); putWord(31, 88);
    inQ[0] = 0; inCount = 1; runProg(cyc);
    check("R9 zero taken", outQ[0], 88);
    inQ[0] = 6; runProg(cyc);
    check("R9 zero not taken", outQ[0], 6);
    inQ[0] = -6; runProg(cyc);
    check("R9 zero not taken negative", outQ[0], -6);

    // R9 unconditional jump skips the word at 01
    putWord(0, 4003); putWord(1, 1131); putWord(2, 4300); putWord(3, 1130);
    putWord(4, 4300); putWord(30, 11); putWord(31, 22);
    inCount = 0; runProg(cyc);
    check("R9 jump target output", outQ[0], 11);
    check("R9 jump single output", outCount, 1);

    // R11 undefined codes and negative instruction word
    putWord(0, 1250); runProg(cyc);
    check("R11 code 12 errFlag", int'(errFlag), 1);
    check("R12 code 12 cycles", cyc, 3);
    putWord(0, 0); runProg(cyc);
    check("R11 code 0 errFlag", int'(errFlag), 1);
    putWord(0, -1); runProg(cyc);
    check("R11 negative word errFlag", int'(errFlag), 1);
    check("R11 halted", int'(halted), 1);

    // R11 R12 fetch past last address
    putWord(0, 4099); putWord(99, 2098); putWord(98, 55); runProg(cyc);
    check("R11 past end errFlag", int'(errFlag), 1);
    check("R12 past end cycles", cyc, 7);

    // R1 R4 R5: stalls, ignored host writes, same-cycle input and host write
    putWord(0, 1020); putWord(1, 1120); putWord(2, 1121); putWord(3, 4300);
    putWord(20, 5); putWord(21, 77);
    inCount = 0; updateIn();
    start = 1'b1; @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R12 read enters execute third cycle", int'(inReady), 1);
    for (int k = 0; k < 4; k++) begin
      check("R4 inReady held", int'(inReady), 1);
      check("R4 stall not halted", int'(halted), 0);
      if (k == 1) begin
        loadEn = 1'b1; loadAddr = AW'(21); loadData = 16'(1234);
      end else loadEn = 1'b0;
      @(negedge clk);
    end
    loadEn = 1'b0;
    inValid = 1'b1; inData = 16'(321);
    loadEn = 1'b1; loadAddr = AW'(20); loadData = 16'(4444);
    @(negedge clk);
    inValid = 1'b0; loadEn = 1'b0;
    check("R4 inReady drops after handshake", int'(inReady), 0);
    outReady = 1'b0;
    @(negedge clk); @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check("R5 outValid held", int'(outValid), 1);
      check("R1 R4 input wins over host write", int'(outData), 321);
      @(negedge clk);
    end
    outReady = 1'b1;
    @(negedge clk);
    waitOut(v);
    check("R1 host write ignored while running", v, 77);
    repeat (4) @(negedge clk);
    check("R10 halted after stop", int'(halted), 1);
    check("R10 no error on stop", int'(errFlag), 0);
    repeat (10) @(negedge clk);
    check("R10 halted holds without start", int'(halted), 1);
    check("R5 no output while halted", int'(outValid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule